// File: doc/BRIEF.md
# Floating-Point Control Word and Deferred Exception Unit

This block keeps the 16-bit floating-point control word and the six sticky exception flags of the floating-point status word. It decides when a pending exception turns into an exception request. A control-word load can unmask a flag that is already set. That load never raises the exception itself. Instead, the request is deferred until the next floating-point instruction that issues with the waiting qualifier.

The arithmetic unit reports new exceptions through a set vector, and those bits accumulate in the flags. A clear command wipes the flags. Two system-control bits, one for emulation and one for a pending task switch, block control-word loads. A blocked load reports a device-not-available fault and leaves the control word unchanged. Memory addressing, protection checks and the arithmetic itself belong to neighbouring blocks.

Top module: `fcw_xcpt_unit`

## Requirements
- R1: During and right after a synchronous active-high reset, `ctrl_word` reads 0x037F, the flags and the summary bit read 0, and `xcpt_req` and `dna_fault` are 0.
- R2: A load (`ld_valid`=1 with `sys_emul`=0 and `sys_tswitch`=0) replaces all 16 bits of `ctrl_word` with `ld_data`, visible from the next cycle. Without a load, `ctrl_word` holds its value.
- R3: `xcpt_req` is 1 only in a cycle where `iss_valid`=1 and `iss_wait`=1. A control-word load alone never raises it.
- R4: Flag i sits in `stat_word` bit i and is masked by `ctrl_word` bit i (0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision; 1 = masked). A waiting issue raises `xcpt_req` in that same cycle exactly when some flag is set with its mask bit clear.
- R5: An issue with `iss_wait`=0 never raises `xcpt_req` and leaves the flags as they were, so a later waiting issue still sees the pending exception.
- R6: `clr_cmd` clears every flag from the next cycle. When `clr_cmd` and `flag_set` arrive in the same cycle, the clear wins.
- R7: Bits of `flag_set` are ORed into the flags from the next cycle and stay set until a clear. A waiting issue that raises `xcpt_req` does not clear them.
- R8: A load while `sys_emul` or `sys_tswitch` is 1 leaves `ctrl_word` unchanged and pulses `dna_fault` for exactly the next cycle.
- R9: `stat_word` bit 7 reads 1 exactly when some flag is set with its mask bit clear. The condition-code bits (8, 9, 10, 14) and the other bits are driven to 0 and have no defined meaning.
- R10: A waiting issue in the same cycle as a load is judged against the control word from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Control-word load strobe |
| ld_data | input | 16 | New control-word value |
| clr_cmd | input | 1 | Clear all exception flags |
| iss_valid | input | 1 | Floating-point instruction issue strobe |
| iss_wait | input | 1 | Issue qualifier: 1 = waiting, 0 = no-wait |
| flag_set | input | 6 | Exception flags raised by the arithmetic unit |
| sys_emul | input | 1 | System emulation bit |
| sys_tswitch | input | 1 | System task-switched bit |
| ctrl_word | output | 16 | Current control word |
| stat_word | output | 16 | Flags in bits 5:0, summary in bit 7 |
| xcpt_req | output | 1 | Deferred floating-point exception request |
| dna_fault | output | 1 | Device-not-available fault pulse |

## Verification
The properties assume that every input is a known 0 or 1 after reset. They also assume that `iss_wait` only has meaning while `iss_valid` is high, and that `ld_data` is stable for the cycle in which `ld_valid` is sampled. The stimulus meets these assumptions in two ways:
- It drives every input on the falling edge and returns unused inputs to zero in every cycle, so no X or stale qualifier reaches a rising edge.
- It presents at most one load and one issue per cycle.

Several cases are deliberately placed in the same cycle: load with issue, clear with set, and blocked load with issue. This exercises the ordering rules.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  // Number of exception flags and their mask bits
  localparam int unsigned XCPT_CNT = 6;

  // Width of the control and status words
  localparam int unsigned WORD_W = 16;

  // Status-word bit carrying the unmasked-pending summary
  localparam int unsigned SUMMARY_POS = 7;

  // Control word after reset: all exceptions masked
  localparam logic [WORD_W-1:0] CW_RESET = 16'h037F;

  // Index of each exception flag and its mask bit
  typedef enum logic [2:0] {
    XC_INVALID  = 3'd0,
    XC_DENORM   = 3'd1,
    XC_ZERODIV  = 3'd2,
    XC_OVERFLOW = 3'd3,
    XC_UNDERFLW = 3'd4,
    XC_PRECISN  = 3'd5
  } xcpt_idx_e;

endpackage

// File: rtl/fcw_ctrl_reg.sv
module fcw_ctrl_reg #(
  parameter int unsigned CW_W = 16,
  parameter logic [CW_W-1:0] RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  input  logic [CW_W-1:0] ld_data,
  input  logic            ld_block,
  output logic [CW_W-1:0] cw_q,
  output logic            dna_q
);

  logic ld_take;
  assign ld_take = ld_valid & ~ld_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q  <= RESET_VAL;
      dna_q <= 1'b0;
    end else begin
      // A blocked load faults for one cycle and keeps the old word
      dna_q <= ld_valid & ld_block;
      if (ld_take) begin
        cw_q <= ld_data;
      end
    end
  end

endmodule

// File: rtl/fcw_flag_reg.sv
module fcw_flag_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set_in,
  output logic [N-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (clr) begin
      // A clear overrides any flag raised in the same cycle
      flags_q <= '0;
    end else begin
      flags_q <= flags_q | set_in;
    end
  end

endmodule

// File: rtl/fcw_xcpt_eval.sv
module fcw_xcpt_eval #(
  parameter int unsigned N = 6
) (
  input  logic         [N-1:0] flags,
  input  logic         [N-1:0] masks,
  input  logic                 iss_valid,
  input  logic                 iss_wait,
  output logic         [N-1:0] pend_vec,
  output logic                 summary,
  output logic                 req
);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_pend
      assign pend_vec[gi] = flags[gi] & ~masks[gi];
    end
  endgenerate

  assign summary = |pend_vec;

  // Only a waiting instruction turns pending state into a request
  assign req = iss_valid & iss_wait & summary;

endmodule

// File: rtl/fcw_xcpt_unit.sv
module fcw_xcpt_unit #(
  parameter int unsigned CW_W     = fcw_pkg::WORD_W,
  parameter int unsigned NUM_XCPT = fcw_pkg::XCPT_CNT,
  parameter int unsigned SUM_POS  = fcw_pkg::SUMMARY_POS,
  parameter logic [CW_W-1:0] CW_INIT = fcw_pkg::CW_RESET
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_valid,
  input  logic [CW_W-1:0]     ld_data,
  input  logic                clr_cmd,
  input  logic                iss_valid,
  input  logic                iss_wait,
  input  logic [NUM_XCPT-1:0] flag_set,
  input  logic                sys_emul,
  input  logic                sys_tswitch,
  output logic [CW_W-1:0]     ctrl_word,
  output logic [CW_W-1:0]     stat_word,
  output logic                xcpt_req,
  output logic                dna_fault
);

  localparam int unsigned MASK_LSB = 0;
  localparam int unsigned MASK_MSB = MASK_LSB + NUM_XCPT - 1;

  logic [CW_W-1:0]     cw_q;
  logic [NUM_XCPT-1:0] flags_q;
  logic [NUM_XCPT-1:0] pend_vec;
  logic                summary;
  logic                ld_block;

  assign ld_block = sys_emul | sys_tswitch;

  fcw_ctrl_reg #(
    .CW_W      (CW_W),
    .RESET_VAL (CW_INIT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .ld_block (ld_block),
    .cw_q     (cw_q),
    .dna_q    (dna_fault)
  );

  fcw_flag_reg #(
    .N (NUM_XCPT)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_cmd),
    .set_in  (flag_set),
    .flags_q (flags_q)
  );

  fcw_xcpt_eval #(
    .N (NUM_XCPT)
  ) u_eval (
    .flags     (flags_q),
    .masks     (cw_q[MASK_MSB:MASK_LSB]),
    .iss_valid (iss_valid),
    .iss_wait  (iss_wait),
    .pend_vec  (pend_vec),
    .summary   (summary),
    .req       (xcpt_req)
  );

  // Status word: flags, summary bit, everything else (incl. condition codes) tied low
  genvar gs;
  generate
    for (gs = 0; gs < CW_W; gs++) begin : g_sw
      if (gs < NUM_XCPT) begin : g_flag
        assign stat_word[gs] = flags_q[gs];
      end else if (gs == SUM_POS) begin : g_sum
        assign stat_word[gs] = summary;
      end else begin : g_zero
        assign stat_word[gs] = 1'b0;
      end
    end
  endgenerate

  assign ctrl_word = cw_q;

  logic unused_pend;
  assign unused_pend = ^pend_vec;

endmodule

// File: rtl/fcw_xcpt_unit_chk.sv
module fcw_xcpt_unit_chk #(
  parameter int unsigned CW_W     = 16,
  parameter int unsigned NUM_XCPT = 6,
  parameter int unsigned SUM_POS  = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                ld_valid,
  input logic [CW_W-1:0]     ld_data,
  input logic                clr_cmd,
  input logic                iss_valid,
  input logic                iss_wait,
  input logic [NUM_XCPT-1:0] flag_set,
  input logic                sys_emul,
  input logic                sys_tswitch,
  input logic [CW_W-1:0]     ctrl_word,
  input logic [CW_W-1:0]     stat_word,
  input logic                xcpt_req,
  input logic                dna_fault
);

  logic [NUM_XCPT-1:0] flg;
  assign flg = stat_word[NUM_XCPT-1:0];

  // R2
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !sys_emul && !sys_tswitch) |=> (ctrl_word == $past(ld_data)));

  // R2
  cw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> $stable(ctrl_word));

  // R3
  req_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
    xcpt_req |-> (iss_valid && iss_wait));

  // R4
  req_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_wait && ((flg & ~ctrl_word[NUM_XCPT-1:0]) != '0)) |-> xcpt_req);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (flg == '0));

  // R7
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_cmd |=> ((flg & $past(flg)) == $past(flg)) && ((flg & $past(flag_set)) == $past(flag_set)));

  // R8
  blocked_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && (sys_emul || sys_tswitch)) |=> (dna_fault && $stable(ctrl_word)));

  // R8
  dna_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && (sys_emul || sys_tswitch)) |=> !dna_fault);

  // R9
  summary_bit_chk: assert property (@(posedge clk) disable iff (rst)
    stat_word[SUM_POS] == ((flg & ~ctrl_word[NUM_XCPT-1:0]) != '0));

endmodule

bind fcw_xcpt_unit fcw_xcpt_unit_chk #(
  .CW_W     (CW_W),
  .NUM_XCPT (NUM_XCPT),
  .SUM_POS  (SUM_POS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ld_valid    (ld_valid),
  .ld_data     (ld_data),
  .clr_cmd     (clr_cmd),
  .iss_valid   (iss_valid),
  .iss_wait    (iss_wait),
  .flag_set    (flag_set),
  .sys_emul    (sys_emul),
  .sys_tswitch (sys_tswitch),
  .ctrl_word   (ctrl_word),
  .stat_word   (stat_word),
  .xcpt_req    (xcpt_req),
  .dna_fault   (dna_fault)
);

// File: tb/tb_fcw_xcpt_unit.sv
module tb_fcw_xcpt_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_data = '0;
  logic        clr_cmd = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_wait = 1'b0;
  logic [5:0]  flag_set = '0;
  logic        sys_emul = 1'b0;
  logic        sys_tswitch = 1'b0;
  logic [15:0] ctrl_word;
  logic [15:0] stat_word;
  logic        xcpt_req;
  logic        dna_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fcw_xcpt_unit dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
    .clr_cmd(clr_cmd), .iss_valid(iss_valid), .iss_wait(iss_wait),
    .flag_set(flag_set), .sys_emul(sys_emul), .sys_tswitch(sys_tswitch),
    .ctrl_word(ctrl_word), .stat_word(stat_word), .xcpt_req(xcpt_req),
    .dna_fault(dna_fault)
  );

  typedef struct {
    string       tag;
    logic        req;
    logic [15:0] cw;
    logic [5:0]  fl;
    logic        sm;
    logic        dna;
  } exp_t;

  exp_t sbq[$];

  // Reference model state
  logic [15:0] m_cw = 16'h037F;
  logic [5:0]  m_fl = '0;

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one call = one cycle of stimulus plus one expected item
  task automatic step(input string tag, input bit ld, input logic [15:0] d, input bit clr,
                      input bit iss, input bit wt, input logic [5:0] fs,
                      input bit em, input bit ts);
    exp_t e;
    @(negedge clk);
    ld_valid = ld; ld_data = d; clr_cmd = clr; iss_valid = iss; iss_wait = wt;
    flag_set = fs; sys_emul = em; sys_tswitch = ts;
    e.tag = tag;
    e.req = iss && wt && ((m_fl & ~m_cw[5:0]) != 6'd0);
    e.dna = ld && (em || ts);
    if (ld && !(em || ts)) m_cw = d;
    m_fl = clr ? 6'd0 : (m_fl | fs);
    e.cw = m_cw;
    e.fl = m_fl;
    e.sm = ((m_fl & ~m_cw[5:0]) != 6'd0);
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
  endtask

  // Monitor: combinational request before the edge, registered state after it
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        cmp(e.tag, "xcpt_req", {15'd0, xcpt_req}, {15'd0, e.req});
        @(posedge clk);
        #(CLK_P/4);
        cmp(e.tag, "ctrl_word", ctrl_word, e.cw);
        cmp(e.tag, "flags", {10'd0, stat_word[5:0]}, {10'd0, e.fl});
        cmp(e.tag, "summary", {15'd0, stat_word[7]}, {15'd0, e.sm});
        cmp(e.tag, "dna_fault", {15'd0, dna_fault}, {15'd0, e.dna});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(CLK_P/4);
    // R1 reset state
    cmp("R1", "ctrl_word", ctrl_word, 16'h037F);
    cmp("R1", "flags", {10'd0, stat_word[5:0]}, 16'h0);
    cmp("R1", "summary", {15'd0, stat_word[7]}, 16'h0);
    cmp("R1", "xcpt_req", {15'd0, xcpt_req}, 16'h0);
    cmp("R1", "dna_fault", {15'd0, dna_fault}, 16'h0);

    // R7 set divide-by-zero flag, still masked
    step("R7", 0, 16'h0, 0, 0, 0, 6'b000100, 0, 0);
    // R4 waiting issue with masked flag: no request
    step("R4", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    // R10 R3 unmasking load with waiting issue in the same cycle: old mask applies
    step("R10", 1, 16'h037B, 0, 1, 1, 6'd0, 0, 0);
    // R4 next waiting issue raises the request
    step("R4", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    // R5 no-wait issues never raise it, pending stays
    step("R5", 0, 16'h0, 0, 1, 0, 6'd0, 0, 0);
    step("R5", 0, 16'h0, 0, 1, 0, 6'd0, 0, 0);
    // R7 flags survive a raised request
    step("R7", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    // R8 blocked loads: emulation, then task-switched
    step("R8", 1, 16'h0000, 0, 0, 0, 6'd0, 1, 0);
    step("R8", 1, 16'hFFFF, 0, 1, 1, 6'd0, 0, 1);
    idle("R8");
    // R6 clear beats a simultaneous set
    step("R6", 0, 16'h0, 1, 0, 0, 6'b100001, 0, 0);
    step("R6", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    // R3 unmask everything via a load with no pending flag, no request
    step("R3", 1, 16'h0000, 0, 0, 0, 6'd0, 0, 0);
    step("R9", 0, 16'h0, 0, 0, 0, 6'b100000, 0, 0);
    step("R4", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    // R3 a load that re-unmasks pending flags does not raise by itself
    step("R3", 1, 16'h0040, 0, 0, 0, 6'd0, 0, 0);
    // R2 arbitrary patterns
    step("R2", 1, 16'hA5C3, 0, 0, 0, 6'd0, 0, 0);
    step("R2", 1, 16'h5A3C, 0, 0, 0, 6'd0, 0, 0);
    step("R2", 1, 16'hFFFF, 1, 0, 0, 6'd0, 0, 0);
    // R4 R9 each flag against its own mask bit
    for (int i = 0; i < 6; i++) begin
      step("R6", 0, 16'h0, 1, 0, 0, 6'd0, 0, 0);
      step("R7", 1, 16'h037F, 0, 0, 0, 6'd1 << i, 0, 0);
      step("R4", 1, 16'h037F & ~(16'd1 << i), 0, 1, 1, 6'd0, 0, 0);
      step("R4", 1, 16'h0040 | (16'h003F & ~(16'd1 << ((i + 1) % 6))) | (16'd1 << i), 0, 1, 1, 6'd0, 0, 0);
      step("R9", 1, 16'h037F & ~(16'd1 << ((i + 1) % 6)), 0, 1, 1, 6'd0, 0, 0);
      step("R4", 0, 16'h0, 0, 1, 1, 6'd0, 0, 0);
    end
    idle("R1");
    idle("R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule